// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block keeps the drive state of a three-phase half bridge for a sensorless brushless motor controller. It has seven states. One parking state turns on three switches to hold the rotor at a known angle before start-up. Six commutating states each turn on one low-side switch and one high-side switch. A step strobe moves the machine forward one state at a time. The strobe normally comes from the speed oscillator of the phase-locked loop.

Each state also names the phase that is not driven. The back-EMF sampler must read that phase. The block puts out raw switch requests and a two-bit sample-select code. PWM gating, braking, protection and output polarity are all handled downstream. A mode input sets the start-up phase:
- In align mode the block is held in the parking state.
- In ramp and run modes the block steps through the commutation cycle.

Top module: `cmt_six_step`

## Requirements
- R1: While `rst_ni` is low, the block is in the parking state: `lo_req_o` = 3'b010, `hi_req_o` = 3'b101, `sample_sel_o` = 2'b11.
- R2: Mode code 2'b00 (align) parks the block from the next clock edge on, and `step_i` has no effect in that mode.
- R3: Mode code 2'b11 (reserved) behaves exactly like align.
- R4: In ramp (2'b01) or run (2'b10), a strobe seen in the parking state moves the block to state A.
- R5: In ramp or run, each strobe advances A→B→C→D→E→F, and F goes back to A. The change is visible one clock edge after the strobe is sampled.
- R6: The switch requests use bit 0 = phase A, bit 1 = phase B, bit 2 = phase C. They are given as low/high per state: A = 100/001, B = 100/010, C = 001/010, D = 001/100, E = 010/100, F = 010/001.
- R7: The sample-select code is 2'b00 for phase A, 2'b01 for phase B, 2'b10 for phase C and 2'b11 for none. States A and D select B, states B and E select A, states C and F select C, and the parking state selects none.
- R8: In ramp or run with no strobe and no clear, the state holds.
- R9: In every commutating state exactly one low and one high request are set, on different phases, and the sampled phase has neither request set. In the parking state exactly three requests are set.
- R10: `clear_i` parks the block at the next edge, with priority over the strobe and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to the parking state |
| step_i | input | 1 | Commutation step strobe, one cycle per step |
| mode_i | input | 2 | 00 align, 01 ramp, 10 run, 11 reserved (treated as align) |
| lo_req_o | output | 3 | Low-side switch requests, bit n = phase n (A, B, C) |
| hi_req_o | output | 3 | High-side switch requests, bit n = phase n |
| sample_sel_o | output | 2 | Undriven phase to sample, 11 = none |

## Verification
Every output is decoded from one state register. A strobe, a mode change or a clear sampled at a rising edge is therefore visible on the outputs right after that edge. An asynchronous reset acts with no edge at all.

The driver applies each stimulus at a falling edge. It then queues the state an independent model expects one edge later. The monitor takes one item from the queue 5 ns after each rising edge. Every comparison falls in the cycle where the result is due, never on the edge itself. Hold cycles and ignored strobes are queued like any other stimulus, so an unwanted step shows up at the ports in the next sample.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

  localparam int PH_N  = 3;
  localparam int SEL_W = $clog2(PH_N + 1);
  localparam int ST_W  = $clog2(2 * PH_N + 1);

  localparam logic [SEL_W-1:0] SEL_NONE = {SEL_W{1'b1}};
  localparam logic [PH_N-1:0]  PARK_LO  = 3'b010;
  localparam logic [PH_N-1:0]  PARK_HI  = 3'b101;

  typedef enum logic [ST_W-1:0] {
    ST_PARK = 3'd0,
    ST_A    = 3'd1,
    ST_B    = 3'd2,
    ST_C    = 3'd3,
    ST_D    = 3'd4,
    ST_E    = 3'd5,
    ST_F    = 3'd6
  } cmt_state_e;

  typedef enum logic [1:0] {
    MODE_ALIGN = 2'd0,
    MODE_RAMP  = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_RSVD  = 2'd3
  } cmt_mode_e;

  // phase index driven low in a commutating state
  function automatic logic [SEL_W-1:0] lo_phase(cmt_state_e st);
    case (st)
      ST_A, ST_B: lo_phase = 2'd2;
      ST_C, ST_D: lo_phase = 2'd0;
      default:    lo_phase = 2'd1;
    endcase
  endfunction

  // phase index driven high in a commutating state
  function automatic logic [SEL_W-1:0] hi_phase(cmt_state_e st);
    case (st)
      ST_A, ST_F: hi_phase = 2'd0;
      ST_B, ST_C: hi_phase = 2'd1;
      default:    hi_phase = 2'd2;
    endcase
  endfunction

  function automatic cmt_state_e advance(cmt_state_e st);
    case (st)
      ST_PARK, ST_F: advance = ST_A;
      default:       advance = cmt_state_e'(st + 1'b1);
    endcase
  endfunction

endpackage

// File: rtl/cmt_seq.sv
`timescale 1ns/1ps
module cmt_seq
  import cmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic [1:0] mode_i,
  output cmt_state_e state_o
);

  cmt_state_e state_q, state_d;
  cmt_mode_e  mode;
  logic       parked;

  assign mode   = cmt_mode_e'(mode_i);
  assign parked = (mode == MODE_ALIGN) || (mode == MODE_RSVD);

  always_comb begin
    state_d = state_q;
    if (clear_i || parked) state_d = ST_PARK;
    else if (step_i)       state_d = advance(state_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PARK;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_align_park_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (state_q == ST_PARK));

  p_rsvd_park_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (state_q == ST_PARK));

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK && step_i && !clear_i && mode_i[0] != mode_i[1])
    |=> (state_q == ST_A));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_F && step_i && !clear_i && mode_i[0] != mode_i[1])
    |=> (state_q == ST_A));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i && mode_i[0] != mode_i[1]) |=> $stable(state_q));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_q == ST_PARK));

endmodule

// File: rtl/cmt_decode.sv
`timescale 1ns/1ps
module cmt_decode
  import cmt_pkg::*;
(
  input  cmt_state_e             state_i,
  output logic [PH_N-1:0]        lo_o,
  output logic [PH_N-1:0]        hi_o,
  output logic [SEL_W-1:0]       sel_o
);

  logic             park;
  logic [SEL_W-1:0] lo_idx, hi_idx;

  assign park   = (state_i == ST_PARK);
  assign lo_idx = lo_phase(state_i);
  assign hi_idx = hi_phase(state_i);

  for (genvar p = 0; p < PH_N; p++) begin : g_phase
    assign lo_o[p] = park ? PARK_LO[p] : (lo_idx == SEL_W'(p));
    assign hi_o[p] = park ? PARK_HI[p] : (hi_idx == SEL_W'(p));
  end

  // undriven phase is the index sum complement: 0+1+2 = 3
  assign sel_o = park ? SEL_NONE : SEL_W'(3 - lo_idx - hi_idx);

endmodule

// File: rtl/cmt_six_step.sv
`timescale 1ns/1ps
module cmt_six_step
  import cmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic [1:0] mode_i,
  output logic [2:0] lo_req_o,
  output logic [2:0] hi_req_o,
  output logic [1:0] sample_sel_o
);

  cmt_state_e state;

  cmt_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .step_i  (step_i),
    .mode_i  (mode_i),
    .state_o (state)
  );

  cmt_decode u_dec (
    .state_i (state),
    .lo_o    (lo_req_o),
    .hi_o    (hi_req_o),
    .sel_o   (sample_sel_o)
  );

  p_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_sel_o != 2'b11) |->
      ($countones(lo_req_o) == 1 && $countones(hi_req_o) == 1 &&
       (lo_req_o & hi_req_o) == 3'b000));

  p_park_three_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_sel_o == 2'b11) |-> ($countones({lo_req_o, hi_req_o}) == 3));

  p_sample_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_sel_o != 2'b11) |->
      (!lo_req_o[sample_sel_o] && !hi_req_o[sample_sel_o]));

endmodule

// File: tb/cmt_six_step_test.sv
`timescale 1ns/1ps
module cmt_six_step_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       step = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] lo, hi;
  logic [1:0] sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] lo;
    logic [2:0] hi;
    logic [1:0] sel;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   model = 0; // 0 = park, 1..6 = A..F

  always #10 clk = ~clk;

  cmt_six_step uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clear_i      (clear),
    .step_i       (step),
    .mode_i       (mode),
    .lo_req_o     (lo),
    .hi_req_o     (hi),
    .sample_sel_o (sel)
  );

  function automatic exp_t expect_of(int s, string tag);
    exp_t e;
    e.tag = tag;
    case (s)
      1: begin e.lo = 3'b100; e.hi = 3'b001; e.sel = 2'b01; end
      2: begin e.lo = 3'b100; e.hi = 3'b010; e.sel = 2'b00; end
      3: begin e.lo = 3'b001; e.hi = 3'b010; e.sel = 2'b10; end
      4: begin e.lo = 3'b001; e.hi = 3'b100; e.sel = 2'b01; end
      5: begin e.lo = 3'b010; e.hi = 3'b100; e.sel = 2'b00; end
      6: begin e.lo = 3'b010; e.hi = 3'b001; e.sel = 2'b10; end
      default: begin e.lo = 3'b010; e.hi = 3'b101; e.sel = 2'b11; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [1:0] m, input logic s, input logic c,
                       input string tag);
    @(negedge clk);
    mode = m; step = s; clear = c;
    if (c || m == 2'b00 || m == 2'b11) model = 0;
    else if (s) model = (model == 6) ? 1 : model + 1;
    q.push_back(expect_of(model, tag));
  endtask

  // monitor: sample 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lo !== e.lo || hi !== e.hi || sel !== e.sel) begin
          errors++;
          $display("FAIL %s: got lo=%b hi=%b sel=%b, expected lo=%b hi=%b sel=%b",
                   e.tag, lo, hi, sel, e.lo, e.hi, e.sel);
        end
        checks++;
        if (sel != 2'b11) begin
          if ($countones(lo) != 1 || $countones(hi) != 1 || (lo & hi) != 0 ||
              lo[sel] || hi[sel]) begin
            errors++;
            $display("FAIL R9: got lo=%b hi=%b sel=%b, expected one pair off phase %0d",
                     lo, hi, sel, sel);
          end
        end else if ($countones({lo, hi}) != 3) begin
          errors++;
          $display("FAIL R9: got %0d requests, expected 3 in park",
                   $countones({lo, hi}));
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: park while in reset
    #15;
    checks++;
    if (lo !== 3'b010 || hi !== 3'b101 || sel !== 2'b11) begin
      errors++;
      $display("FAIL R1: got lo=%b hi=%b sel=%b, expected 010 101 11", lo, hi, sel);
    end
    @(negedge clk); rst_n = 1'b1;

    drive(2'b00, 1'b1, 1'b0, "R2 strobe ignored in align");
    drive(2'b00, 1'b1, 1'b0, "R2 strobe ignored in align");
    drive(2'b01, 1'b0, 1'b0, "R8 hold in park");
    drive(2'b01, 1'b1, 1'b0, "R4 park to A");
    drive(2'b01, 1'b1, 1'b0, "R6 R7 state B");
    drive(2'b01, 1'b0, 1'b0, "R8 hold B");
    drive(2'b01, 1'b1, 1'b0, "R6 R7 state C");
    drive(2'b10, 1'b1, 1'b0, "R6 R7 state D");
    drive(2'b10, 1'b1, 1'b0, "R6 R7 state E");
    drive(2'b10, 1'b1, 1'b0, "R6 R7 state F");
    drive(2'b10, 1'b0, 1'b0, "R8 hold F");
    drive(2'b10, 1'b1, 1'b0, "R5 wrap F to A");
    for (int i = 0; i < 8; i++) drive(2'b10, 1'b1, 1'b0, "R5 cycle");
    drive(2'b00, 1'b0, 1'b0, "R2 align parks");
    drive(2'b10, 1'b1, 1'b0, "R4 run park to A");
    drive(2'b10, 1'b1, 1'b0, "R5 A to B");
    drive(2'b11, 1'b1, 1'b0, "R3 reserved parks");
    drive(2'b11, 1'b1, 1'b0, "R3 reserved ignores strobe");
    drive(2'b01, 1'b1, 1'b0, "R4 ramp park to A");
    drive(2'b01, 1'b1, 1'b0, "R5 A to B");
    drive(2'b10, 1'b1, 1'b1, "R10 clear beats strobe");
    drive(2'b10, 1'b0, 1'b0, "R10 stays parked");
    drive(2'b10, 1'b1, 1'b0, "R4 after clear");
    drive(2'b10, 1'b1, 1'b0, "R5 A to B");
    drive(2'b10, 1'b0, 1'b0, "R8 hold B");

    // R1: asynchronous reset mid-run
    wait (q.size() == 0);
    @(negedge clk);
    step = 1'b0;
    rst_n = 1'b0;
    #2;
    checks++;
    if (lo !== 3'b010 || hi !== 3'b101 || sel !== 2'b11) begin
      errors++;
      $display("FAIL R1: got lo=%b hi=%b sel=%b, expected 010 101 11", lo, hi, sel);
    end
    @(negedge clk); rst_n = 1'b1; model = 0;
    drive(2'b10, 1'b0, 1'b0, "R1 parked after reset");
    drive(2'b10, 1'b1, 1'b0, "R4 start after reset");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule